// File: doc/BRIEF.md
# Single-Bit Relay-Logic Control Core

This block is the execution core of a one-bit controller meant to stand in for relay ladder circuits. Each accepted cycle it takes a 4-bit operation code and a single data bit on separate lines, combines the data bit with its one-bit result register, and may emit a stored bit with a write strobe or a one-cycle pulse on a sequencing line. It has no program counter, no memory and no addresses. An external instruction store, counter and return stack decide what arrives next. They react to the jump, return and no-op pulses this core produces.

Two enable latches gate the datapath. The input enable forces the data bit to read as 0 for every load and logic operation. The output enable suppresses the write strobe. A conditional skip operation can cancel the next accepted slot when the result register is 0. The operation stream arrives as `op_valid_i`, which qualifies `op_code_i` and `op_data_i`. The core has no back-pressure: it accepts every cycle in which `op_valid_i` is high. A cycle with `op_valid_i` low is a bubble, and it leaves all state untouched. Every output is registered, so the effect of an operation accepted at one rising edge is visible from that edge until the next one.

Top module: `bitctl_core`

## Requirements
- R1: After reset the result bit, the store data bit, the write strobe and all four pulse outputs are 0, both enable latches are 1, and no skip is pending.
- R2: Codes 1/2 load the data bit, or its inverse, into the result bit. Codes 3/4 AND the result bit with the data bit or its inverse. Codes 5/6 OR the result bit with the data bit or its inverse.
- R3: Code 7 sets the result bit to 1 when it equals the data bit and clears it to 0 when the two differ.
- R4: Code 10 loads the raw data bit into the input enable. While the input enable is 0, codes 1 to 7 see the data bit as 0, so a load gives 0 and an inverted load gives 1.
- R5: Code 8 drives the result bit onto `store_data_o` and code 9 drives its inverse. Each pulses `store_wr_o` high for exactly one cycle when the output enable is 1.
- R6: Code 11 loads the raw data bit into the output enable. While it is 0, codes 8 and 9 produce no strobe and leave `store_data_o` unchanged.
- R7: Codes 0, 15, 12 and 13 pulse `flag_o_o`, `flag_f_o`, `jump_o` and `return_o` respectively for one cycle and leave the result bit unchanged. At most one strobe or pulse output is high in any cycle.
- R8: Code 14 with a result bit of 0 cancels exactly the next accepted operation. The cancelled operation changes no state and raises no strobe or pulse. With a result bit of 1, code 14 has no effect.
- R9: A cycle with `op_valid_i` low changes no state, raises no strobe or pulse, and keeps a pending skip for the next accepted operation.
- R10: Outputs change only at the rising edge that accepts an operation. Before that edge the previous values remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation code and data bit are valid this cycle |
| op_code_i | input | 4 | Operation code |
| op_data_i | input | 1 | Data bit |
| rr_o | output | 1 | Result bit |
| store_data_o | output | 1 | Bit driven by the last enabled store |
| store_wr_o | output | 1 | One-cycle write strobe for a store |
| flag_o_o | output | 1 | One-cycle pulse for no-op code 0 |
| flag_f_o | output | 1 | One-cycle pulse for no-op code 15 |
| jump_o | output | 1 | One-cycle jump pulse |
| return_o | output | 1 | One-cycle return pulse |

## Verification
The logic operations are driven with all four pairs of result bit and data bit. This shows the plain forms from the inverted ones and tells the equality test from a plain load. The loads are then repeated with the input enable cleared. This separates masking the data bit from masking the result. Skip sequences are tried with a result bit of 0 and of 1, with a store, a no-op or a load as the cancelled slot, and with bubbles between the skip and its victim. This shows whether the skip consumes exactly one accepted slot and not one clock cycle.

// File: rtl/bitctl_pkg.sv
package bitctl_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOPO = 4'h0, OP_LD   = 4'h1, OP_LDC  = 4'h2, OP_AND  = 4'h3,
    OP_ANDC = 4'h4, OP_OR   = 4'h5, OP_ORC  = 4'h6, OP_XNOR = 4'h7,
    OP_STO  = 4'h8, OP_STOC = 4'h9, OP_IEN  = 4'hA, OP_OEN  = 4'hB,
    OP_JMP  = 4'hC, OP_RTN  = 4'hD, OP_SKZ  = 4'hE, OP_NOPF = 4'hF
  } op_e;

  typedef enum logic [2:0] {
    FN_KEEP, FN_LOAD, FN_AND, FN_OR, FN_EQ
  } fn_e;

  typedef struct packed {
    fn_e  fn;
    logic inv_data;
    logic store;
    logic store_inv;
    logic set_ien;
    logic set_oen;
    logic pulse_o;
    logic pulse_f;
    logic pulse_jmp;
    logic pulse_ret;
    logic skip_zero;
  } ctl_t;
endpackage

// File: rtl/bitctl_decode.sv
module bitctl_decode
  import bitctl_pkg::*;
(
  input  logic [OP_W-1:0] code_i,
  output ctl_t            ctl_o
);
  always_comb begin
    ctl_o    = '0;
    ctl_o.fn = FN_KEEP;
    case (op_e'(code_i))
      OP_NOPO: ctl_o.pulse_o = 1'b1;
      OP_LD:   ctl_o.fn = FN_LOAD;
      OP_LDC:  begin ctl_o.fn = FN_LOAD; ctl_o.inv_data = 1'b1; end
      OP_AND:  ctl_o.fn = FN_AND;
      OP_ANDC: begin ctl_o.fn = FN_AND;  ctl_o.inv_data = 1'b1; end
      OP_OR:   ctl_o.fn = FN_OR;
      OP_ORC:  begin ctl_o.fn = FN_OR;   ctl_o.inv_data = 1'b1; end
      OP_XNOR: ctl_o.fn = FN_EQ;
      OP_STO:  ctl_o.store = 1'b1;
      OP_STOC: begin ctl_o.store = 1'b1; ctl_o.store_inv = 1'b1; end
      OP_IEN:  ctl_o.set_ien = 1'b1;
      OP_OEN:  ctl_o.set_oen = 1'b1;
      OP_JMP:  ctl_o.pulse_jmp = 1'b1;
      OP_RTN:  ctl_o.pulse_ret = 1'b1;
      OP_SKZ:  ctl_o.skip_zero = 1'b1;
      OP_NOPF: ctl_o.pulse_f = 1'b1;
      default: ctl_o.fn = FN_KEEP;
    endcase
  end
endmodule

// File: rtl/bitctl_alu.sv
module bitctl_alu
  import bitctl_pkg::*;
(
  input  fn_e  fn_i,
  input  logic inv_i,
  input  logic rr_i,
  input  logic data_i,
  output logic rr_next_o
);
  logic opnd;
  assign opnd = inv_i ? ~data_i : data_i;

  always_comb begin
    case (fn_i)
      FN_LOAD: rr_next_o = opnd;
      FN_AND:  rr_next_o = rr_i & opnd;
      FN_OR:   rr_next_o = rr_i | opnd;
      FN_EQ:   rr_next_o = ~(rr_i ^ opnd);
      default: rr_next_o = rr_i;
    endcase
  end
endmodule

// File: rtl/bitctl_core.sv
module bitctl_core
  import bitctl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            op_valid_i,
  input  logic [OP_W-1:0] op_code_i,
  input  logic            op_data_i,
  output logic            rr_o,
  output logic            store_data_o,
  output logic            store_wr_o,
  output logic            flag_o_o,
  output logic            flag_f_o,
  output logic            jump_o,
  output logic            return_o
);
  ctl_t ctl;
  logic rr_q, ien_q, oen_q, skip_q;
  logic sdat_q, wr_q, fo_q, ff_q, jmp_q, ret_q;
  logic run, data_eff, rr_next;

  bitctl_decode u_dec (
    .code_i (op_code_i),
    .ctl_o  (ctl)
  );

  assign run      = op_valid_i & ~skip_q;
  assign data_eff = op_data_i & ien_q;

  bitctl_alu u_alu (
    .fn_i      (ctl.fn),
    .inv_i     (ctl.inv_data),
    .rr_i      (rr_q),
    .data_i    (data_eff),
    .rr_next_o (rr_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q   <= 1'b0;
      ien_q  <= 1'b1;
      oen_q  <= 1'b1;
      skip_q <= 1'b0;
      sdat_q <= 1'b0;
      wr_q   <= 1'b0;
      fo_q   <= 1'b0;
      ff_q   <= 1'b0;
      jmp_q  <= 1'b0;
      ret_q  <= 1'b0;
    end else begin
      wr_q  <= 1'b0;
      fo_q  <= 1'b0;
      ff_q  <= 1'b0;
      jmp_q <= 1'b0;
      ret_q <= 1'b0;
      if (op_valid_i) begin
        skip_q <= run & ctl.skip_zero & ~rr_q;
      end
      if (run) begin
        rr_q <= rr_next;
        if (ctl.set_ien) ien_q <= op_data_i;
        if (ctl.set_oen) oen_q <= op_data_i;
        if (ctl.store && oen_q) begin
          sdat_q <= ctl.store_inv ? ~rr_q : rr_q;
          wr_q   <= 1'b1;
        end
        fo_q  <= ctl.pulse_o;
        ff_q  <= ctl.pulse_f;
        jmp_q <= ctl.pulse_jmp;
        ret_q <= ctl.pulse_ret;
      end
    end
  end

  assign rr_o         = rr_q;
  assign store_data_o = sdat_q;
  assign store_wr_o   = wr_q;
  assign flag_o_o     = fo_q;
  assign flag_f_o     = ff_q;
  assign jump_o       = jmp_q;
  assign return_o     = ret_q;
endmodule

// File: rtl/bitctl_core_chk.sv
module bitctl_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       op_valid_i,
  input logic [3:0] op_code_i,
  input logic       rr_o,
  input logic       store_data_o,
  input logic       store_wr_o,
  input logic       flag_o_o,
  input logic       flag_f_o,
  input logic       jump_o,
  input logic       return_o,
  input logic       skip_pend
);
  AST_ONE_PULSE_AT_MOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({store_wr_o, flag_o_o, flag_f_o, jump_o, return_o})); // R7

  AST_FLAG_OPS_KEEP_RR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && (op_code_i == 4'h0 || op_code_i == 4'hF ||
                    op_code_i == 4'hC || op_code_i == 4'hD)) |=> $stable(rr_o)); // R7

  AST_STORE_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_wr_o |-> (store_data_o == (($past(op_code_i) == 4'h8) ? $past(rr_o) : ~$past(rr_o)))); // R5

  AST_SKIPPED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && skip_pend) |=> ($stable(rr_o) && $stable(store_data_o) && !store_wr_o &&
                                   !flag_o_o && !flag_f_o && !jump_o && !return_o)); // R8

  AST_SKIP_ONE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && skip_pend) |=> !skip_pend); // R8

  AST_BUBBLE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> ($stable(rr_o) && $stable(store_data_o) && $stable(skip_pend) &&
                     !store_wr_o && !flag_o_o && !flag_f_o && !jump_o && !return_o)); // R9
endmodule

bind bitctl_core bitctl_core_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .op_valid_i   (op_valid_i),
  .op_code_i    (op_code_i),
  .rr_o         (rr_o),
  .store_data_o (store_data_o),
  .store_wr_o   (store_wr_o),
  .flag_o_o     (flag_o_o),
  .flag_f_o     (flag_f_o),
  .jump_o       (jump_o),
  .return_o     (return_o),
  .skip_pend    (skip_q)
);

// File: tb/bitctl_core_tb_top.sv
`timescale 1ns/1ps
module bitctl_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic [3:0] code = 4'h0;
  logic       dat = 1'b0;
  logic rr, sd, wr, fo, ff, jmp, ret;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bitctl_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(vld), .op_code_i(code),
    .op_data_i(dat), .rr_o(rr), .store_data_o(sd), .store_wr_o(wr),
    .flag_o_o(fo), .flag_f_o(ff), .jump_o(jmp), .return_o(ret)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chk_pulses(input string req, input logic [4:0] exp);
    chk(req, "store_wr", wr, exp[4]);
    chk(req, "flag_o", fo, exp[3]);
    chk(req, "flag_f", ff, exp[2]);
    chk(req, "jump", jmp, exp[1]);
    chk(req, "return", ret, exp[0]);
  endtask

  // drive at falling edge, let one rising edge accept it, sample 2 ns later
  task automatic op(input logic [3:0] c, input logic d);
    @(negedge clk);
    vld = 1'b1; code = c; dat = d;
    @(posedge clk);
    #2;
    vld = 1'b0;
  endtask

  task automatic bubble(input logic [3:0] c, input logic d);
    @(negedge clk);
    vld = 1'b0; code = c; dat = d;
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset;
    chk("R1", "rr after reset", rr, 1'b0);
    chk("R1", "store data after reset", sd, 1'b0);
    chk_pulses("R1", 5'b00000);
    op(4'h1, 1'b1);
    chk("R1", "input enable set at reset", rr, 1'b1);
    op(4'h8, 1'b0);
    chk("R1", "output enable set at reset", wr, 1'b1);
  endtask

  task automatic t_logic;
    op(4'h1, 1'b1); chk("R2", "LD 1", rr, 1'b1);
    op(4'h4, 1'b1); chk("R2", "ANDC 1", rr, 1'b0);
    op(4'h6, 1'b0); chk("R2", "ORC 0", rr, 1'b1);
    op(4'h3, 1'b0); chk("R2", "AND 0", rr, 1'b0);
    op(4'h5, 1'b1); chk("R2", "OR 1", rr, 1'b1);
    op(4'h2, 1'b1); chk("R2", "LDC 1", rr, 1'b0);
    op(4'h2, 1'b0); chk("R2", "LDC 0", rr, 1'b1);
    op(4'h4, 1'b0); chk("R2", "ANDC 0", rr, 1'b1);
    op(4'h3, 1'b1); chk("R2", "AND 1", rr, 1'b1);
    op(4'h1, 1'b0); chk("R2", "LD 0", rr, 1'b0);
    op(4'h6, 1'b1); chk("R2", "ORC 1 on 0", rr, 1'b0);
    op(4'h5, 1'b0); chk("R2", "OR 0 on 0", rr, 1'b0);
  endtask

  task automatic t_xnor;
    op(4'h1, 1'b1);
    op(4'h7, 1'b1); chk("R3", "XNOR 1,1", rr, 1'b1);
    op(4'h7, 1'b0); chk("R3", "XNOR 1,0", rr, 1'b0);
    op(4'h7, 1'b0); chk("R3", "XNOR 0,0", rr, 1'b1);
    op(4'h1, 1'b0);
    op(4'h7, 1'b1); chk("R3", "XNOR 0,1", rr, 1'b0);
  endtask

  task automatic t_ien;
    op(4'hA, 1'b0);
    op(4'h1, 1'b1); chk("R4", "LD 1 masked", rr, 1'b0);
    op(4'h2, 1'b1); chk("R4", "LDC 1 masked", rr, 1'b1);
    op(4'h1, 1'b1);
    op(4'h5, 1'b1); chk("R4", "OR 1 masked", rr, 1'b0);
    op(4'hA, 1'b1);
    op(4'h1, 1'b1); chk("R4", "LD 1 after re-enable", rr, 1'b1);
  endtask

  task automatic t_store;
    op(4'h1, 1'b1);
    op(4'h8, 1'b0);
    chk("R5", "STO data", sd, 1'b1);
    chk_pulses("R5", 5'b10000);
    op(4'h1, 1'b1);
    chk("R5", "strobe one cycle", wr, 1'b0);
    op(4'h9, 1'b1);
    chk("R5", "STOC data", sd, 1'b0);
    chk("R5", "STOC strobe", wr, 1'b1);
  endtask

  task automatic t_oen;
    op(4'hB, 1'b0);
    op(4'h1, 1'b1);
    op(4'h8, 1'b0);
    chk("R6", "STO disabled strobe", wr, 1'b0);
    chk("R6", "STO disabled data held", sd, 1'b0);
    op(4'hB, 1'b1);
    op(4'h8, 1'b0);
    chk("R6", "STO re-enabled strobe", wr, 1'b1);
    chk("R6", "STO re-enabled data", sd, 1'b1);
  endtask

  task automatic t_flags;
    op(4'h1, 1'b1);
    op(4'h0, 1'b0); chk_pulses("R7 NOPO", 5'b01000); chk("R7", "NOPO rr", rr, 1'b1);
    op(4'hF, 1'b0); chk_pulses("R7 NOPF", 5'b00100); chk("R7", "NOPF rr", rr, 1'b1);
    op(4'hC, 1'b0); chk_pulses("R7 JMP", 5'b00010); chk("R7", "JMP rr", rr, 1'b1);
    op(4'hD, 1'b0); chk_pulses("R7 RTN", 5'b00001); chk("R7", "RTN rr", rr, 1'b1);
    op(4'h1, 1'b0); chk_pulses("R7 after", 5'b00000);
  endtask

  task automatic t_skip;
    op(4'h1, 1'b0);
    op(4'hE, 1'b0); chk_pulses("R8 SKZ", 5'b00000);
    op(4'h1, 1'b1); chk("R8", "skipped LD", rr, 1'b0);
    op(4'h1, 1'b1); chk("R8", "LD after skip", rr, 1'b1);
    op(4'hE, 1'b0);
    op(4'h1, 1'b0); chk("R8", "no skip when rr=1", rr, 1'b0);
    op(4'hE, 1'b0);
    op(4'h9, 1'b0);
    chk("R8", "skipped STOC strobe", wr, 1'b0);
    chk("R8", "skipped STOC data", sd, 1'b1);
    op(4'h0, 1'b0); chk("R8", "slot after skipped one runs", fo, 1'b1);
    op(4'hE, 1'b0);
    op(4'hC, 1'b0); chk("R8", "skipped JMP", jmp, 1'b0);
  endtask

  task automatic t_bubble;
    op(4'h1, 1'b1);
    bubble(4'h1, 1'b0);
    chk("R9", "bubble rr", rr, 1'b1);
    bubble(4'h0, 1'b0);
    chk_pulses("R9 bubble", 5'b00000);
    op(4'h1, 1'b0);
    op(4'hE, 1'b0);
    bubble(4'h1, 1'b1);
    bubble(4'h1, 1'b1);
    op(4'h1, 1'b1); chk("R9", "skip kept across bubbles", rr, 1'b0);
    op(4'h1, 1'b1); chk("R9", "next slot runs", rr, 1'b1);
  endtask

  task automatic t_timing;
    op(4'h1, 1'b0);
    @(negedge clk);
    vld = 1'b1; code = 4'h1; dat = 1'b1;
    #1;
    chk("R10", "rr before edge", rr, 1'b0);
    @(posedge clk);
    #2;
    vld = 1'b0;
    chk("R10", "rr after edge", rr, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
    t_reset();
    t_logic();
    t_xnor();
    t_ien();
    t_store();
    t_oen();
    t_flags();
    t_skip();
    t_bubble();
    t_timing();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule